// File: doc/BRIEF.md
# Even/Odd Split Carry-less Polynomial Multiplier

The block multiplies two binary polynomials, each with `L` coefficients, over GF(2). It returns the full unreduced product of `2L-1` coefficients. Binary-field elliptic curve datapaths use it ahead of a separate reduction stage. Coefficients combine only with AND and XOR, so no carries ever form.

Operands are not cut into upper and lower halves. Each operand is split by the parity of its coefficient index:
- the even-indexed bits form one half polynomial;
- the odd-indexed bits form the other, so A = AE(y) + x·AO(y) with y = x².

The three half-size products AE·BE, AO·BO and (AE+AO)(BE+BO) are built by the same split, applied recursively down to a two-coefficient base case. Their results are woven back together with a single XOR level per recursion step. The multiply is combinational and is captured in an output register.

Top module: `parity_kara_mul`

## Requirements
- R1: One clock after a cycle with `in_valid` high, bit k of `prod_out` equals the XOR over all i+j=k of `a_in[i] & b_in[j]` for the operands presented in that cycle. Here k runs over 0..2L-2, bit 0 is the constant coefficient and bit `L-1` of each operand is its highest coefficient.
- R2: A zero operand, on either side, yields an all-zero product.
- R3: For operands x^i and x^j (bit i and bit j set alone), the product has only bit i+j set.
- R4: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was sampled high, and `prod_out` updates on that same edge.
- R5: After a cycle with `in_valid` low, `out_valid` is low and `prod_out` keeps its previous value whatever the operand inputs carry.
- R6: `rst` is synchronous and active high. The edge that samples it high clears `out_valid` and `prod_out` to zero, even when `in_valid` is high in the same cycle.
- R7: The design is correct for every power-of-two `L` from 2 to 256. At L = 2 the product is formed directly. A value of `L` that is not a power of two, or is below 2, stops elaboration.
- R8: Two all-ones operands give a product whose bit k is 1 exactly when min(k, 2L-2-k)+1 is odd.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on `a_in`/`b_in` are to be multiplied |
| a_in | input | L | First operand, bit i is the coefficient of x^i |
| b_in | input | L | Second operand, bit i is the coefficient of x^i |
| out_valid | output | 1 | `prod_out` holds a fresh product this cycle |
| prod_out | output | 2L-1 | Registered unreduced product |

## Verification
The bench runs four instances side by side, at L = 2, 4, 16 and 64, all fed from slices of one operand pair.

An exhaustive sweep of all 4-bit operand pairs covers the first two sizes completely. Its random upper bits exercise the larger sizes. A full single-bit grid at L = 64 places every i+j product position alone. It separates a coefficient that lands at a wrong even/odd position from a missing cross term.

Zero and all-ones operands expose stuck or dropped XOR terms in the recombination. Idle cycles with changing operands, and a reset raised together with `in_valid`, show the register capture and hold rules.

// File: rtl/pkm_pkg.sv
package pkm_pkg;

    // True when n is a power of two of at least 2
    function automatic bit is_pow2(input int n);
        return (n >= 2) && ((n & (n - 1)) == 0);
    endfunction

    // Number of coefficients in the unreduced product of two n-term polynomials
    function automatic int prod_width(input int n);
        return 2 * n - 1;
    endfunction

endpackage

// File: rtl/pkm_split.sv
// Separates an operand into its even-indexed and odd-indexed coefficients.
module pkm_split #(
    parameter int W = 4
) (
    input  logic [W-1:0]   vec,
    output logic [W/2-1:0] even_q,
    output logic [W/2-1:0] odd_q
);
    localparam int H = W / 2;

    for (genvar i = 0; i < H; i++) begin : g_lane
        assign even_q[i] = vec[2*i];
        assign odd_q[i]  = vec[2*i+1];
    end
endmodule

// File: rtl/pkm_merge.sv
// Weaves three half-size products, written in y = x^2, back into x.
// Even result bits take ee + y*oo; odd bits take mid + ee + oo.
// Every result bit sits behind one XOR level.
module pkm_merge #(
    parameter int W = 4
) (
    input  logic [W-2:0]   p_ee,
    input  logic [W-2:0]   p_oo,
    input  logic [W-2:0]   p_mid,
    output logic [2*W-2:0] p_out
);
    localparam int H = W / 2;

    for (genvar k = 0; k < W; k++) begin : g_even
        if (k == 0) begin : g_lo
            assign p_out[0] = p_ee[0];
        end else if (k == W - 1) begin : g_hi
            assign p_out[2*k] = p_oo[k-1];
        end else begin : g_mid
            assign p_out[2*k] = p_ee[k] ^ p_oo[k-1];
        end
    end

    for (genvar k = 0; k < W - 1; k++) begin : g_odd
        assign p_out[2*k+1] = p_mid[k] ^ p_ee[k] ^ p_oo[k];
    end
endmodule

// File: rtl/pkm_core.sv
// Recursive even/odd split multiplier, purely combinational.
module pkm_core #(
    parameter int W = 4
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-2:0] p
);
    localparam int H  = W / 2;
    localparam int HP = 2 * H - 1;

    logic [H-1:0]  a_ev, a_od, b_ev, b_od, a_sum, b_sum;
    logic [HP-1:0] pr_ee, pr_oo, pr_mid;

    pkm_split #(.W(W)) u_split_a (.vec(a), .even_q(a_ev), .odd_q(a_od));
    pkm_split #(.W(W)) u_split_b (.vec(b), .even_q(b_ev), .odd_q(b_od));

    assign a_sum = a_ev ^ a_od;
    assign b_sum = b_ev ^ b_od;

    if (W == 2) begin : g_base
        assign pr_ee  = a_ev & b_ev;
        assign pr_oo  = a_od & b_od;
        assign pr_mid = a_sum & b_sum;
    end else begin : g_rec
        pkm_core #(.W(H)) u_ee  (.a(a_ev),  .b(b_ev),  .p(pr_ee));
        pkm_core #(.W(H)) u_oo  (.a(a_od),  .b(b_od),  .p(pr_oo));
        pkm_core #(.W(H)) u_mid (.a(a_sum), .b(b_sum), .p(pr_mid));
    end

    pkm_merge #(.W(W)) u_merge (
        .p_ee (pr_ee),
        .p_oo (pr_oo),
        .p_mid(pr_mid),
        .p_out(p)
    );
endmodule

// File: rtl/parity_kara_mul.sv
module parity_kara_mul #(
    parameter int L = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [L-1:0]         a_in,
    input  logic [L-1:0]         b_in,
    output logic                 out_valid,
    output logic [2*L-2:0]       prod_out
);
    localparam int PW = pkm_pkg::prod_width(L);

    if (!pkm_pkg::is_pow2(L)) begin : g_bad_len
        $error("parity_kara_mul: L must be a power of two of at least 2");
    end

    typedef struct packed {
        logic          vld;
        logic [PW-1:0] prod;
    } mul_state_t;

    mul_state_t    st_d, st_q;
    logic [PW-1:0] mul_res;

    pkm_core #(.W(L)) u_core (.a(a_in), .b(b_in), .p(mul_res));

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.prod = mul_res;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign prod_out  = st_q.prod;
endmodule

// File: rtl/pkm_checker.sv
module pkm_checker #(
    parameter int L = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [L-1:0]   a_in,
    input logic [L-1:0]   b_in,
    input logic           out_valid,
    input logic [2*L-2:0] prod_out
);
    // R6: a sampled reset leaves both outputs cleared
    a_r6_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && prod_out == '0));

    // R4: an accepted operand pair raises out_valid on the next edge
    a_r4_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R5: no request means no valid pulse
    a_r5_idle_low: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R5: no request means the held product does not move
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(prod_out));

    // R1: constant coefficient is the AND of the two constant terms
    a_r1_low_coeff: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> prod_out[0] == ($past(a_in[0]) & $past(b_in[0])));

    // R1: top coefficient is the AND of the two leading terms
    a_r1_top_coeff: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> prod_out[2*L-2] == ($past(a_in[L-1]) & $past(b_in[L-1])));
endmodule

bind parity_kara_mul pkm_checker #(.L(L)) u_pkm_checker (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .a_in     (a_in),
    .b_in     (b_in),
    .out_valid(out_valid),
    .prod_out (prod_out)
);

// File: tb/parity_kara_mul_test.sv
module parity_kara_mul_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vld = 1'b0;
    logic [63:0] a_v = '0;
    logic [63:0] b_v = '0;
    int          errors = 0;
    int          checks = 0;
    bit          done   = 1'b0;

    always #5 clk = ~clk;

    logic         ov2, ov4, ov16, ov64;
    logic [2:0]   p2;
    logic [6:0]   p4;
    logic [30:0]  p16;
    logic [126:0] p64;

    parity_kara_mul #(.L(16)) uut (
        .clk(clk), .rst(rst), .in_valid(vld), .a_in(a_v[15:0]), .b_in(b_v[15:0]),
        .out_valid(ov16), .prod_out(p16));
    parity_kara_mul #(.L(2)) uut_l2 (
        .clk(clk), .rst(rst), .in_valid(vld), .a_in(a_v[1:0]), .b_in(b_v[1:0]),
        .out_valid(ov2), .prod_out(p2));
    parity_kara_mul #(.L(4)) uut_l4 (
        .clk(clk), .rst(rst), .in_valid(vld), .a_in(a_v[3:0]), .b_in(b_v[3:0]),
        .out_valid(ov4), .prod_out(p4));
    parity_kara_mul #(.L(64)) uut_l64 (
        .clk(clk), .rst(rst), .in_valid(vld), .a_in(a_v), .b_in(b_v),
        .out_valid(ov64), .prod_out(p64));

    // Schoolbook carry-less product of the low n coefficients
    function automatic logic [127:0] clmul(input logic [63:0] a, input logic [63:0] b, input int n);
        logic [127:0] r = '0;
        for (int i = 0; i < n; i++)
            for (int j = 0; j < n; j++)
                if (a[j] && b[i]) r[i+j] = ~r[i+j];
        return r;
    endfunction

    task automatic cmp(input string req, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, tag, act, exp);
        end
    endtask

    task automatic cmp_all_prod(input string req, input logic [63:0] a, input logic [63:0] b);
        cmp(req, "L2 prod",  {125'd0, p2},  clmul(a, b, 2));
        cmp(req, "L4 prod",  {121'd0, p4},  clmul(a, b, 4));
        cmp(req, "L16 prod", {97'd0, p16},  clmul(a, b, 16));
        cmp(req, "L64 prod", {1'b0, p64},   clmul(a, b, 64));
    endtask

    task automatic cmp_valid(input string req, input logic exp);
        cmp(req, "valid", {124'd0, ov2, ov4, ov16, ov64}, {124'd0, {4{exp}}});
    endtask

    // Present one pair for one cycle, then sample after the capturing edge
    task automatic run_vec(input logic [63:0] a, input logic [63:0] b, input string req);
        @(negedge clk);
        a_v = a; b_v = b; vld = 1'b1;
        @(negedge clk);
        vld = 1'b0;
        cmp_valid("R4", 1'b1);
        cmp_all_prod(req, a, b);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] ones;
        logic [127:0] ones_exp;
        logic [30:0] held16;
        logic [126:0] held64;

        repeat (3) @(negedge clk);
        cmp_valid("R6", 1'b0);
        cmp("R6", "L16 prod after reset", {97'd0, p16}, '0);
        cmp("R6", "L64 prod after reset", {1'b0, p64}, '0);
        rst = 1'b0;

        // R1 / R7: exhaustive over 4-bit pairs, random upper coefficients
        for (int rep = 0; rep < 4; rep++) begin
            for (int i = 0; i < 256; i++) begin
                logic [63:0] ra, rb;
                ra = {$urandom(), $urandom()};
                rb = {$urandom(), $urandom()};
                ra[3:0] = i[3:0];
                rb[3:0] = i[7:4];
                run_vec(ra, rb, "R1/R7");
            end
        end

        // R2: zero on either side
        run_vec('0, 64'hDEAD_BEEF_0123_4567, "R2");
        run_vec(64'hFFFF_0000_A5A5_5A5A, '0, "R2");
        run_vec('0, '0, "R2");

        // R3: single-bit grid at L=64
        for (int i = 0; i < 64; i++) begin
            for (int j = 0; j < 64; j++) begin
                logic [127:0] e;
                run_vec(64'd1 << i, 64'd1 << j, "R3");
                e = 128'd1 << (i + j);
                cmp("R3", "L64 single bit", {1'b0, p64}, e);
            end
        end

        // R8: all-ones parity pattern, computed from the closed form
        ones = '1;
        run_vec(ones, ones, "R8");
        ones_exp = '0;
        for (int k = 0; k <= 126; k++) begin
            int m;
            m = (k < 126 - k) ? k : 126 - k;
            ones_exp[k] = ((m + 1) % 2) == 1;
        end
        cmp("R8", "L64 all ones", {1'b0, p64}, ones_exp);

        // R5: idle cycles with moving operands leave outputs held
        run_vec(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, "R1");
        held16 = p16;
        held64 = p64;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            a_v = {$urandom(), $urandom()};
            b_v = {$urandom(), $urandom()};
            @(negedge clk);
            cmp_valid("R5", 1'b0);
            cmp("R5", "L16 held", {97'd0, p16}, {97'd0, held16});
            cmp("R5", "L64 held", {1'b0, p64}, {1'b0, held64});
        end

        // R6: reset wins over a same-cycle request
        @(negedge clk);
        a_v = '1; b_v = '1; vld = 1'b1; rst = 1'b1;
        @(negedge clk);
        vld = 1'b0; rst = 1'b0;
        cmp_valid("R6", 1'b0);
        cmp("R6", "L64 prod cleared", {1'b0, p64}, '0);

        // R1: a final random batch after reset
        for (int i = 0; i < 64; i++) begin
            run_vec({$urandom(), $urandom()}, {$urandom(), $urandom()}, "R1");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule